// File: doc/BRIEF.md
# Multi-Mode Stereo Serial Sample Transmitter

This block turns a stereo pair of 18-bit two's-complement samples into a serial bit stream. The stream leaves on `dout`, and in master framings a frame marker leaves on `fsync_out`. The serial bit clock (`sclk`) and the channel clock (`lrclk`) come from a separate clock block. All logic runs on the fast system clock `clk`, and the block treats `sclk` and `lrclk` as level inputs whose edges it detects. A new bit is presented after every falling edge of `sclk`. The left word goes out while `lrclk` is high and the right word while it is low.

A 3-bit `mode` code selects one of eight framings:

| Code | Role | Word | Order / framing |
|------|------|------|-----------------|
| 000 | slave | up to 18 bits | MSB first, word length set by the number of bit clocks the host supplies |
| 001 | slave | 18 bits | LSB first, right-justified against a measured half-frame length |
| 010 | slave | 18 bits | MSB first, `fsync_in` gates which slots carry bits |
| 011 | master | 16 bits | MSB delayed one slot, level frame marker |
| 100 | master | 18 bits | MSB first, pulsed frame marker |
| 101 | master | 18 bits | LSB first, right-justified, pulsed frame marker |
| 110 | master | 16 bits | MSB first, half-rate 16-slot halves |
| 111 | master | 16 bits | LSB first, half-rate 16-slot halves |

Sample pairs enter through a valid/ready port into a one-entry staging register. A source may hold `in_valid` high with stable data for as long as `in_ready` is low. A pair is taken on any `clk` edge where both are high. The staged pair moves into the holding registers on the next rising edge of `lrclk`, and `in_ready` rises again at that point. The block therefore accepts at most one pair per frame. When no pair was staged at the rising edge, the previous pair is sent again.

Top module: `multimode_stereo_tx`

## Requirements
- R1: `in_ready` is high whenever the staging register is empty. After a pair is accepted, `in_ready` stays low until the next rising `lrclk` edge moves the pair into the holding registers. A frame with no staged pair repeats the previous pair.
- R2: In the slave codes 000, 001 and 010, `fsync_out` stays low.
- R3: Code 011 places bits 17..2 of the sample MSB-first in slots 1..16 of each half-frame, where slot 0 is the first `sclk` fall after an `lrclk` edge. `fsync_out` is high exactly in slots 1..16.
- R4: Code 100 sends bits 17..0 in slots 0..17. Code 101 sends bits 0..17 in slots 14..31, so the MSB occupies the last slot of a 32-slot half-frame.
- R5: Code 110 sends bits 17..2 MSB-first in slots 0..15. Code 111 sends bits 2..17 LSB-first in slots 0..15. Each half-frame has 16 slots.
- R6: Code 000 sends bit 17−s in slot s for s < 18. A host that supplies fewer clocks truncates the word, and slots 18 and above drive 0.
- R7: Code 001 sends bit s+18−L in slot s when that index lies in 0..17, and 0 otherwise. L is the number of slots in the previous half-frame. L is 32 for the first half-frame after reset.
- R8: `dout` changes only in the `clk` cycle after an `sclk` falling edge. Left data is sent while `lrclk` is high and right data while it is low.
- R9: Code 010 drives a bit only in slots where `fsync_in` is high. The n-th gated slot of a half-frame carries bit 17−n, gated slots past the 18th drive 0, and ungated slots drive 0.
- R10: Both words of a pair are latched together on the `lrclk` rising edge. A pair accepted during the left half does not change the right half that follows.
- R11: After reset `dout` and `fsync_out` are 0 and `in_ready` is 1.
- R12: In codes 100, 101, 110 and 111, `fsync_out` is a one-slot pulse on the first data slot of each half-frame. That slot is slot 14 for code 101 and slot 0 for the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Framing code, held stable while running |
| sclk | input | 1 | Serial bit clock from the clock block |
| lrclk | input | 1 | Channel clock, high for left and low for right |
| fsync_in | input | 1 | Slot gate used by code 010 |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The staging register can take a pair |
| in_left | input | 18 | Left sample, two's complement |
| in_right | input | 18 | Right sample, two's complement |
| dout | output | 1 | Serial data |
| fsync_out | output | 1 | Frame marker in master codes |

## Verification
The in-module assertions check four properties on every cycle:
- `dout` moves only after an `sclk` fall.
- The holding registers change only at an `lrclk` rise.
- An accepted pair blocks further pairs.
- A pulsed marker never lasts two slots, and no marker rises in a slave code.

The bench scenarios cover what a property cannot: the bit placed in each slot by each of the eight codes. This includes truncation by a short slave frame, right justification that follows the measured length, gating by `fsync_in`, repetition of a pair when none was offered, and the right half staying on the pair latched at the preceding rising edge.

// File: rtl/mstx_pkg.sv
package mstx_pkg;
  localparam int SAMPLE_W   = 18;
  localparam int SHORT_W    = 16;
  localparam int HALF_LONG  = 32;
  localparam int HALF_SHORT = 16;
  localparam int SLOT_W     = 8;
  localparam int DEF_LEN    = 32;

  typedef enum logic [2:0] {
    M_SLV_MSB   = 3'b000,
    M_SLV_LSB   = 3'b001,
    M_SLV_GATE  = 3'b010,
    M_MST16_DLY = 3'b011,
    M_MST18_MSB = 3'b100,
    M_MST18_LSB = 3'b101,
    M_MST16_MSB = 3'b110,
    M_MST16_LSB = 3'b111
  } tx_mode_e;

  function automatic logic mode_is_master(logic [2:0] m);
    return (m == M_MST16_DLY) || m[2];
  endfunction
endpackage

// File: rtl/mstx_timer.sv
module mstx_timer #(
  parameter int SLOT_W  = mstx_pkg::SLOT_W,
  parameter int DEF_LEN = mstx_pkg::DEF_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              lrclk,
  input  logic              gate,
  output logic              fall,
  output logic              lr_rise,
  output logic [SLOT_W-1:0] idx,
  output logic [SLOT_W-1:0] gidx,
  output logic [SLOT_W-1:0] len
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

  logic sclk_d, lr_d, pend, lr_edge, restart;
  logic [SLOT_W-1:0] slot, gcnt;

  assign fall    = sclk_d & ~sclk;
  assign lr_edge = lrclk ^ lr_d;
  assign lr_rise = lrclk & ~lr_d;
  assign restart = lr_edge | pend;
  assign idx     = restart ? '0 : slot;
  assign gidx    = restart ? '0 : gcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      lr_d   <= 1'b0;
      pend   <= 1'b0;
      slot   <= '0;
      gcnt   <= '0;
      len    <= SLOT_W'(DEF_LEN);
    end else begin
      sclk_d <= sclk;
      lr_d   <= lrclk;
      if (lr_edge && !pend && slot != '0) len <= slot;
      if (fall) begin
        slot <= (idx == SLOT_MAX) ? idx : idx + 1'b1;
        if (gate) gcnt <= (gidx == SLOT_MAX) ? gidx : gidx + 1'b1;
        else      gcnt <= gidx;
        pend <= 1'b0;
      end else if (lr_edge) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mstx_stage.sv
module mstx_stage #(
  parameter int SW = mstx_pkg::SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  input  logic          lrclk,
  input  logic          lr_rise,
  output logic [SW-1:0] cur_word
);
  logic          full;
  logic [SW-1:0] stg_l, stg_r, hold_l, hold_r, nxt_l, nxt_r;

  assign in_ready = ~full;
  assign nxt_l    = full ? stg_l : hold_l;
  assign nxt_r    = full ? stg_r : hold_r;
  assign cur_word = lrclk ? (lr_rise ? nxt_l : hold_l) : hold_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      stg_l  <= '0;
      stg_r  <= '0;
      hold_l <= '0;
      hold_r <= '0;
    end else begin
      if (lr_rise) begin
        hold_l <= nxt_l;
        hold_r <= nxt_r;
      end
      if (in_valid && in_ready) begin
        stg_l <= in_left;
        stg_r <= in_right;
        full  <= 1'b1;
      end else if (lr_rise) begin
        full <= 1'b0;
      end
    end
  end

  // R1: an accepted pair blocks the port until the next lrclk rise
  a_r1_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !lr_rise) |=> !in_ready);

  // R10: both holding words move only at an lrclk rise
  a_r10_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lr_rise) |-> ($stable(hold_l) && $stable(hold_r)));
endmodule

// File: rtl/mstx_framer.sv
module mstx_framer #(
  parameter int SW     = mstx_pkg::SAMPLE_W,
  parameter int HW     = mstx_pkg::SHORT_W,
  parameter int HL     = mstx_pkg::HALF_LONG,
  parameter int SLOT_W = mstx_pkg::SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              fall,
  input  logic [SLOT_W-1:0] idx,
  input  logic [SLOT_W-1:0] gidx,
  input  logic [SLOT_W-1:0] len,
  input  logic              gate,
  input  logic [SW-1:0]     word,
  output logic              dout,
  output logic              fsync_out
);
  import mstx_pkg::*;
  localparam int PW = $clog2(SW);

  logic v, f, d_n, fs_n;
  int   i, g, l, p;

  always_comb begin
    i = int'(idx);
    g = int'(gidx);
    l = int'(len);
    v = 1'b0;
    f = 1'b0;
    p = 0;
    case (mode)
      M_SLV_MSB:   begin v = (i < SW); p = SW - 1 - i; end
      M_SLV_LSB:   begin p = i + SW - l; v = (i < l) && (p >= 0); end
      M_SLV_GATE:  begin v = gate && (g < SW); p = SW - 1 - g; end
      M_MST16_DLY: begin v = (i >= 1) && (i <= HW); p = SW - i; f = v; end
      M_MST18_MSB: begin v = (i < SW); p = SW - 1 - i; f = (i == 0); end
      M_MST18_LSB: begin v = (i >= HL - SW) && (i < HL); p = i - (HL - SW); f = (i == HL - SW); end
      M_MST16_MSB: begin v = (i < HW); p = SW - 1 - i; f = (i == 0); end
      default:     begin v = (i < HW); p = i + (SW - HW); f = (i == 0); end
    endcase
    d_n  = v ? word[PW'(p)] : 1'b0;
    fs_n = mode_is_master(mode) & f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout      <= 1'b0;
      fsync_out <= 1'b0;
    end else if (fall) begin
      dout      <= d_n;
      fsync_out <= fs_n;
    end
  end

  // R8: serial data only moves after an sclk falling edge
  a_r8_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(fall));

  // R12: a pulsed marker lasts a single slot
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2] && fsync_out && fall) |=> !fsync_out);

  // R2: the marker never rises in a slave code
  a_r2_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_out) |-> mode_is_master(mode));
endmodule

// File: rtl/multimode_stereo_tx.sv
module multimode_stereo_tx #(
  parameter int SW     = mstx_pkg::SAMPLE_W,
  parameter int SLOT_W = mstx_pkg::SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          sclk,
  input  logic          lrclk,
  input  logic          fsync_in,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  output logic          dout,
  output logic          fsync_out
);
  logic              fall, lr_rise;
  logic [SLOT_W-1:0] idx, gidx, len;
  logic [SW-1:0]     cur_word;

  mstx_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrclk(lrclk), .gate(fsync_in),
    .fall(fall), .lr_rise(lr_rise), .idx(idx), .gidx(gidx), .len(len)
  );

  mstx_stage #(.SW(SW)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .lrclk(lrclk), .lr_rise(lr_rise),
    .cur_word(cur_word)
  );

  mstx_framer #(.SW(SW), .SLOT_W(SLOT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fall(fall), .idx(idx),
    .gidx(gidx), .len(len), .gate(fsync_in), .word(cur_word),
    .dout(dout), .fsync_out(fsync_out)
  );
endmodule

// File: tb/multimode_stereo_tx_test.sv
`timescale 1ns/1ps
module multimode_stereo_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic sclk = 1'b1, lrclk = 1'b0, fs_in = 1'b0, in_valid = 1'b0;
  logic [17:0] in_left = '0, in_right = '0;
  logic in_ready, dout, fsync_out;
  int nchecks = 0, nerr = 0, mlen = 32;
  bit done = 0;

  always #2.5 clk = ~clk;

  multimode_stereo_tx uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sclk(sclk), .lrclk(lrclk),
    .fsync_in(fs_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .dout(dout), .fsync_out(fsync_out)
  );

  function automatic logic [17:0] pl(int k);
    if (k == 1) return 18'h20000;
    if (k == 2) return 18'h1FFFF;
    return 18'((k * 44701 + 12345) ^ (k << 9));
  endfunction
  function automatic logic [17:0] pr(int k);
    return 18'(pl(k) * 3 + 32'h0A5A5) ^ 18'(k * 77);
  endfunction

  task automatic check(string req, int act, int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // returns {fsync, data} for a slot, built from the requirement text
  function automatic logic [1:0] expect_bits(logic [2:0] md, int s, int g, int len,
                                             bit gt, logic [17:0] w);
    int b;
    logic d, f;
    b = -1; f = 1'b0;
    case (md)
      3'b000: if (s < 18) b = 17 - s;                                    // R6
      3'b001: if (s + 18 - len >= 0 && s + 18 - len <= 17) b = s + 18 - len; // R7
      3'b010: if (gt && g < 18) b = 17 - g;                               // R9
      3'b011: begin if (s >= 1 && s <= 16) begin b = 18 - s; f = 1'b1; end end // R3
      3'b100: begin if (s < 18) b = 17 - s; f = (s == 0); end            // R4
      3'b101: begin if (s >= 14 && s < 32) b = s - 14; f = (s == 14); end // R4
      3'b110: begin if (s < 16) b = 17 - s; f = (s == 0); end            // R5
      default: begin if (s < 16) b = s + 2; f = (s == 0); end            // R5
    endcase
    d = (b >= 0) ? w[b] : 1'b0;
    return {f, d};
  endfunction

  task automatic do_reset(logic [2:0] md);
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b1; lrclk = 1'b0; fs_in = 1'b0; in_valid = 1'b0; mode = md;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mlen = 32;
    check("R11 dout after reset", dout, 0);
    check("R11 fsync after reset", fsync_out, 0);
    check("R11 ready after reset", in_ready, 1);
  endtask

  task automatic push(int k);
    @(negedge clk);
    check("R1 ready before offer", in_ready, 1);
    in_valid = 1'b1; in_left = pl(k); in_right = pr(k);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 ready low while staged", in_ready, 0);
    in_left = ~in_left; in_right = ~in_right;
  endtask

  task automatic run_half(logic lv, int n, logic [17:0] w, logic [2:0] md, string tag);
    int g;
    logic [1:0] e;
    string ft;
    g = 0;
    ft = (md == 3'b011) ? "R3 fsync" : (md[2] ? "R12 fsync" : "R2 fsync");
    for (int s = 0; s < n; s++) begin
      bit gt;
      gt = (md == 3'b010) ? (lv ? (s >= 3 && s < 23) : (s % 3 == 0)) : 1'b0;
      @(negedge clk);
      sclk = 1'b0; lrclk = lv; fs_in = gt;
      @(negedge clk);
      e = expect_bits(md, s, g, mlen, gt, w);
      check($sformatf("%s mode %03b slot %0d %s", tag, md, s, lv ? "left" : "right"),
            dout, e[0]);
      check($sformatf("%s mode %03b slot %0d", ft, md, s), fsync_out, e[1]);
      if (gt) g++;
      @(negedge clk);
      sclk = 1'b1;
      @(negedge clk);
    end
    mlen = n;
  endtask

  task automatic run_mode(logic [2:0] md, int n, int base, string tag);
    int cur;
    do_reset(md);
    cur = base;
    push(cur);
    for (int f = 0; f < 3; f++) begin
      run_half(1'b1, n, pl(cur), md, {tag, "/R8"});
      if (f != 1) push(cur + 1);        // f==1: no new pair, R1 repeat
      run_half(1'b0, n, pr(cur), md, {tag, "/R10"});
      if (f != 1) cur = cur + 1;
    end
  endtask

  initial begin
    run_mode(3'b011, 32, 1, "R3");
    run_mode(3'b100, 32, 2, "R4");
    run_mode(3'b101, 32, 5, "R4");
    run_mode(3'b110, 16, 8, "R5");
    run_mode(3'b111, 16, 11, "R5");
    run_mode(3'b000, 20, 14, "R6");
    run_mode(3'b000, 16, 1, "R6");
    run_mode(3'b001, 24, 17, "R7");
    run_mode(3'b001, 40, 20, "R7");
    run_mode(3'b010, 32, 23, "R9");
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule